// File: doc/BRIEF.md
# I2C master byte engine

This block is a single-master engine for a two-wire serial bus. It moves one byte per command. A host drives it through a small register port. The host sets the bit rate and a power-of-four prescaler, writes the byte to send into the data register, and then writes a control word. The control word issues a START, a repeated START, a STOP or a plain byte transfer. Both bus lines are open-drain: the outputs `scl_oe` and `sda_oe` pull their line low when they are 1. The engine reads the resolved data line back on `sda_in`.

Every completed event (a START, a repeated START, a byte with its acknowledge bit, or lost arbitration) sets `irq`. One clock later, the status register holds a code that names the event. While `irq` is set, the engine holds SCL low and waits. The host writes the control register with the go bit set to clear the flag and launch the next action. A single shift register serves the byte going out and the byte coming in. The acknowledge bit the engine drives when it receives is a separate latched value, taken from the control word.

The direction of the transfer comes from the LSB of the first byte after a START or repeated START (the address byte). When that bit is 1, the bytes that follow are received.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, `irq` is 0, both `scl_oe` and `sda_oe` are 0 (lines released), and the status register (address 4) reads 0xF8.
- R2: During a byte, each SCL high phase and each SCL low phase lasts 8 + B·4^P system clocks. B is the bit-rate register (address 0) and P is the 2-bit prescaler (address 1). The full SCL period is therefore 16 + 2·B·4^P clocks.
- R3: Writing the control register (address 2) with go (bit 0) and start (bit 1) set while idle pulls SDA low while SCL is high (a START). It then drives SCL low and sets `irq` with status 0x08.
- R4: Start plus go, written while the engine owns the bus and `irq` is set, releases SDA and then SCL and issues a new START (a repeated START). This reports status 0x10.
- R5: A byte transfer shifts the data register (address 3) out MSB first, one bit per SCL pulse. SDA changes only while SCL is low.
- R6: After the address byte in write direction, the status is 0x18 if the ninth bit read low (ACK) and 0x20 if it read high (NACK). After a transmitted data byte, the status is 0x28 (ACK) or 0x30 (NACK).
- R7: After an address byte with LSB 1, the status is 0x40 (ACK) or 0x48 (NACK). In that direction the engine releases SDA for eight bits and shifts them into the data register. On the ninth bit it drives low when the ack bit (control bit 3) was 1 at go, and it reports 0x50 for a byte answered with ACK and 0x58 for a byte answered with NACK.
- R8: If SDA reads low during a transmitted bit in which the engine released it, the engine releases both lines, goes idle without a STOP, and sets `irq` with status 0x38.
- R9: The status register reads 0xF8 whenever `irq` is 0, and also in the first cycle `irq` is 1. It shows the event code from the next cycle on.
- R10: While `irq` is set and no go is written, `scl_oe` and `sda_oe` do not change. On the owned bus, SCL is held low.
- R11: Stop plus go (bit 2 and bit 0), written while the engine owns the bus, makes SDA rise while SCL is high (a STOP). The engine returns to idle with both lines released and does not set `irq`.
- R12: A control write or data write made while a transfer is running (`irq` 0, not idle) is ignored. The byte in flight completes unchanged and no STOP is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 rate, 1 prescaler, 2 control, 3 data, 4 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (control reads `irq` in bit 0) |
| irq | output | 1 | Event flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The checker watches four things on every cycle:
- the status read shows 0xF8 whenever the flag is clear and in the cycle the flag rises;
- the bus outputs stay frozen while the flag waits for the host;
- both lines are released after lost arbitration;
- a STOP edge never comes with a flag.

Only the bench scenarios can show the following, because each needs a responding bus partner and a known expected value:
- the SCL phase lengths across the prescaler and bit-rate sweep;
- the byte values seen on the wire and shifted back in;
- the acknowledge-dependent status codes;
- arbitration loss against a competing driver;
- the ignored mid-transfer writes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_STA_HI, S_STA_LO, S_WAIT, S_BIT_LO, S_BIT_HI,
      S_RS_LO, S_RS_HI, S_STP_LO, S_STP_HI, S_STP_END
   } seq_e;

   // register map
   localparam int REG_RATE  = 0;
   localparam int REG_PRESC = 1;
   localparam int REG_CTRL  = 2;
   localparam int REG_DATA  = 3;
   localparam int REG_STAT  = 4;

   // control word bits
   localparam int CB_GO  = 0;
   localparam int CB_STA = 1;
   localparam int CB_STO = 2;
   localparam int CB_ACK = 3;

   // status codes
   localparam logic [7:0] ST_START   = 8'h08;
   localparam logic [7:0] ST_RSTART  = 8'h10;
   localparam logic [7:0] ST_AW_ACK  = 8'h18;
   localparam logic [7:0] ST_AW_NACK = 8'h20;
   localparam logic [7:0] ST_DW_ACK  = 8'h28;
   localparam logic [7:0] ST_DW_NACK = 8'h30;
   localparam logic [7:0] ST_ARB     = 8'h38;
   localparam logic [7:0] ST_AR_ACK  = 8'h40;
   localparam logic [7:0] ST_AR_NACK = 8'h48;
   localparam logic [7:0] ST_DR_ACK  = 8'h50;
   localparam logic [7:0] ST_DR_NACK = 8'h58;
   localparam logic [7:0] ST_NOINFO  = 8'hF8;

endpackage

// File: rtl/i2cm_rate.sv
// Half-period timer: each timed phase lasts BASE_HALF + br * 4^ps clocks.
module i2cm_rate #(
   parameter int BR_W      = 8,
   parameter int PS_W      = 2,
   parameter int BASE_HALF = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [BR_W-1:0] br,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int NSTEP = 1 << PS_W;
   localparam int MAXSH = 2 * (NSTEP - 1);
   localparam int CW    = BR_W + MAXSH + 2;

   logic [CW-1:0] scaled [NSTEP];
   logic [CW-1:0] half;
   logic [CW-1:0] cnt;

   for (genvar k = 0; k < NSTEP; k++) begin : g_scale
      assign scaled[k] = CW'(br) << (2 * k);
   end

   assign half = CW'(BASE_HALF) + scaled[ps];
   assign tick = run && (cnt == half - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/i2cm_flag.sv
// Event flag with a status register that follows it one cycle later.
module i2cm_flag
   import i2cm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set,
   input  logic [7:0] code,
   input  logic       clr,
   output logic       irq,
   output logic [7:0] stat
);
   logic       flag_q;
   logic [7:0] code_q;
   logic [7:0] lag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         code_q <= ST_NOINFO;
         lag_q  <= ST_NOINFO;
      end else begin
         if (set)      flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
         if (set) code_q <= code;
         lag_q <= flag_q ? code_q : ST_NOINFO;
      end
   end

   assign irq  = flag_q;
   assign stat = flag_q ? lag_q : ST_NOINFO;
endmodule

// File: rtl/i2cm_fsm.sv
// Bus sequencer: START / repeated START / STOP, byte shift, ack, arbitration.
module i2cm_fsm
   import i2cm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  logic       sta,
   input  logic       sto,
   input  logic       ackc,
   input  logic       wr_data,
   input  logic [7:0] wdata,
   input  logic       sda_in,
   output logic       run,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic [7:0] dreg,
   output logic       ev,
   output logic [7:0] ev_code
);
   seq_e       st;
   logic [3:0] bc;
   logic [7:0] sh;
   logic       sda_drv, rep, addr_ph, rd, ackq;
   logic       rxd, lost, byte_end, ackd;

   assign rxd      = rd && !addr_ph;
   assign byte_end = (st == S_BIT_HI) && tick && (bc == 4'd8);
   assign lost     = (st == S_BIT_HI) && tick && (bc < 4'd8) && !rxd
                     && !sda_drv && !sda_in;
   assign ackd     = rxd ? ackq : !sda_in;

   assign run    = (st != S_IDLE) && (st != S_WAIT);
   assign scl_oe = (st == S_STA_LO) || (st == S_WAIT) || (st == S_BIT_LO)
                || (st == S_RS_LO)  || (st == S_STP_LO);
   assign sda_oe = sda_drv;
   assign dreg   = sh;

   assign ev = ((st == S_STA_LO) && tick) || byte_end || lost;

   always_comb begin
      ev_code = ST_NOINFO;
      if (st == S_STA_LO)  ev_code = rep ? ST_RSTART : ST_START;
      else if (lost)       ev_code = ST_ARB;
      else if (addr_ph)    ev_code = sh[0] ? (ackd ? ST_AR_ACK : ST_AR_NACK)
                                           : (ackd ? ST_AW_ACK : ST_AW_NACK);
      else if (rd)         ev_code = ackd ? ST_DR_ACK : ST_DR_NACK;
      else                 ev_code = ackd ? ST_DW_ACK : ST_DW_NACK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         bc      <= '0;
         sh      <= '0;
         sda_drv <= 1'b0;
         rep     <= 1'b0;
         addr_ph <= 1'b0;
         rd      <= 1'b0;
         ackq    <= 1'b0;
      end else begin
         if (wr_data && (st == S_IDLE || st == S_WAIT)) sh <= wdata;
         case (st)
            S_IDLE:
               if (go && sta) begin
                  st <= S_STA_HI; sda_drv <= 1'b1; rep <= 1'b0;
               end
            S_STA_HI: if (tick) st <= S_STA_LO;
            S_STA_LO:
               if (tick) begin
                  st <= S_WAIT; addr_ph <= 1'b1; rd <= 1'b0;
               end
            S_WAIT:
               if (go) begin
                  if (sta) begin
                     st <= S_RS_LO; sda_drv <= 1'b0; rep <= 1'b1;
                  end else if (sto) begin
                     st <= S_STP_LO; sda_drv <= 1'b1;
                  end else begin
                     st <= S_BIT_LO; bc <= '0; ackq <= ackc;
                     sda_drv <= rxd ? 1'b0 : ~sh[7];
                  end
               end
            S_BIT_LO: if (tick) st <= S_BIT_HI;
            S_BIT_HI:
               if (tick) begin
                  if (lost) begin
                     st <= S_IDLE; sda_drv <= 1'b0;
                  end else if (bc == 4'd8) begin
                     st <= S_WAIT;
                     if (addr_ph) begin
                        rd <= sh[0]; addr_ph <= 1'b0;
                     end
                  end else begin
                     sh <= {sh[6:0], sda_in};
                     bc <= bc + 4'd1;
                     st <= S_BIT_LO;
                     if (bc == 4'd7) sda_drv <= rxd ? ackq : 1'b0;
                     else            sda_drv <= rxd ? 1'b0 : ~sh[6];
                  end
               end
            S_RS_LO: if (tick) st <= S_RS_HI;
            S_RS_HI:
               if (tick) begin
                  st <= S_STA_HI; sda_drv <= 1'b1;
               end
            S_STP_LO: if (tick) st <= S_STP_HI;
            S_STP_HI:
               if (tick) begin
                  st <= S_STP_END; sda_drv <= 1'b0;
               end
            S_STP_END: if (tick) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
   import i2cm_pkg::*;
#(
   parameter int BR_W      = 8,
   parameter int PS_W      = 2,
   parameter int BASE_HALF = 8,
   parameter int ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              sda_in
);
   if (BR_W < 1 || BR_W > 8) begin : g_bad_br
      $error("BR_W must lie in 1..8");
   end
   if (PS_W < 1 || PS_W > 3) begin : g_bad_ps
      $error("PS_W must lie in 1..3");
   end
   if (BASE_HALF < 2) begin : g_bad_base
      $error("BASE_HALF must be at least 2");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("ADDR_W must be at least 3");
   end

   logic [BR_W-1:0] br_q;
   logic [PS_W-1:0] ps_q;
   logic            ctl_go, data_wr, tick, run, ev;
   logic [7:0]      ev_code, dreg, stat_out;

   assign ctl_go  = reg_wr && (reg_addr == ADDR_W'(REG_CTRL)) && reg_wdata[CB_GO];
   assign data_wr = reg_wr && (reg_addr == ADDR_W'(REG_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_q <= '0;
         ps_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(REG_RATE))  br_q <= reg_wdata[BR_W-1:0];
         if (reg_addr == ADDR_W'(REG_PRESC)) ps_q <= reg_wdata[PS_W-1:0];
      end
   end

   i2cm_rate #(.BR_W(BR_W), .PS_W(PS_W), .BASE_HALF(BASE_HALF)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(run), .br(br_q), .ps(ps_q), .tick(tick)
   );

   i2cm_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(ctl_go),
      .sta(reg_wdata[CB_STA]), .sto(reg_wdata[CB_STO]), .ackc(reg_wdata[CB_ACK]),
      .wr_data(data_wr), .wdata(reg_wdata), .sda_in(sda_in),
      .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe), .dreg(dreg),
      .ev(ev), .ev_code(ev_code)
   );

   i2cm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(ev), .code(ev_code), .clr(ctl_go),
      .irq(irq), .stat(stat_out)
   );

   always_comb begin
      reg_rdata = 8'h00;
      if (reg_addr == ADDR_W'(REG_RATE))       reg_rdata = 8'(br_q);
      else if (reg_addr == ADDR_W'(REG_PRESC)) reg_rdata = 8'(ps_q);
      else if (reg_addr == ADDR_W'(REG_CTRL))  reg_rdata = {7'b0, irq};
      else if (reg_addr == ADDR_W'(REG_DATA))  reg_rdata = dreg;
      else if (reg_addr == ADDR_W'(REG_STAT))  reg_rdata = stat_out;
   end
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
   import i2cm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       irq,
   input logic [7:0] stat_out,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       ctl_go
);
   // R9: no event code without the flag
   a_r9_noinfo: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> stat_out == ST_NOINFO);

   // R9: the code trails the flag by one cycle
   a_r9_lag_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> stat_out == ST_NOINFO);
   a_r9_lag_next: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |=> (!irq || stat_out != ST_NOINFO));

   // R10: outputs frozen while waiting for the host
   a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ctl_go) |=> ($stable(scl_oe) && $stable(sda_oe)));

   // R8: lines released after lost arbitration
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && stat_out == ST_ARB) |-> (!scl_oe && !sda_oe));

   // R11: a STOP edge never raises the flag
   a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> !irq);
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .stat_out(stat_out),
   .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_go(ctl_go)
);

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = 3'd4;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq, scl_oe, sda_oe, sda_in;

   always #2.5 clk = ~clk;

   // bus partner
   logic slv_drv = 1'b0, rival = 1'b0, slv_ack = 1'b1;
   logic [7:0] slv_byte = 8'h00, got = 8'h00;
   logic pscl = 1'b1, psda = 1'b1, aph = 1'b0, srd = 1'b0, quiet = 1'b0, ack_seen = 1'b0;
   int   bc = 0, starts = 0, stops = 0;
   wire  scl_l = ~scl_oe;
   wire  sda_l = ~(sda_oe | slv_drv | rival);
   assign sda_in = sda_l;

   i2c_byte_master u_i2c_byte_master (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
   );

   always @(negedge clk) begin
      logic sc, sd;
      sc = scl_l; sd = sda_l;
      if (pscl && sc && psda && !sd) begin
         starts++; bc = 0; aph = 1'b1; srd = 1'b0; quiet = 1'b0;
      end else if (pscl && sc && !psda && sd) begin
         stops++;
      end else if (!pscl && sc) begin
         if (bc < 8) begin
            got = {got[6:0], sd}; bc++;
         end else begin
            ack_seen = !sd;
            if (aph) begin srd = got[0]; aph = 1'b0; end
            else if (srd && sd) quiet = 1'b1;
            bc = 0;
         end
      end
      if (!sc) begin
         if (quiet)        slv_drv = 1'b0;
         else if (bc == 8) slv_drv = (aph || !srd) ? slv_ack : 1'b0;
         else              slv_drv = (srd && !aph) ? ~slv_byte[7-bc] : 1'b0;
      end
      pscl = sc; psda = sd;
   end

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 3'd4;
   endtask

   task automatic rdreg(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; #1; v = reg_rdata; reg_addr = 3'd4;
   endtask

   task automatic go(input bit sta, input bit sto, input bit ack);
      wr(3'd2, {4'b0, ack, sto, sta, 1'b1});
   endtask

   task automatic wait_irq(output logic [7:0] s0, output logic [7:0] s1);
      int n = 0;
      while (!irq && n < 40000) begin @(negedge clk); n++; end
      s0 = reg_rdata;
      @(negedge clk);
      s1 = reg_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] s0, s1, v;
      int st0, bad, hi, lo, h;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq", irq, 0);
      chk("R1 scl_oe", scl_oe, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 status", reg_rdata, 8'hF8);
      rst_n = 1'b1;
      wr(3'd0, 8'd2); wr(3'd1, 8'd0);

      // R3 / R9: START from idle
      go(1, 0, 0);
      wait_irq(s0, s1);
      chk("R9 first flag cycle", s0, 8'hF8);
      chk("R3 start code", s1, 8'h08);
      chk("R3 start seen", starts, 1);

      // R10: stall holds SCL low
      bad = 0;
      repeat (40) begin @(negedge clk); if (!scl_oe || !irq) bad++; end
      chk("R10 stall", bad, 0);

      // R5 / R6: address write with ACK
      slv_ack = 1'b1;
      wr(3'd3, 8'hA4); go(0, 0, 0);
      wait_irq(s0, s1);
      chk("R6 addr write ack", s1, 8'h18);
      chk("R5 wire byte", got, 8'hA4);

      // R6: data NACK
      slv_ack = 1'b0;
      wr(3'd3, 8'h5B); go(0, 0, 0);
      wait_irq(s0, s1);
      chk("R6 data nack", s1, 8'h30);
      chk("R5 wire byte 2", got, 8'h5B);

      // R12: writes during a running byte are ignored
      slv_ack = 1'b1;
      wr(3'd3, 8'h3C); go(0, 0, 0);
      repeat (15) @(negedge clk);
      go(0, 1, 0);
      wr(3'd3, 8'hFF);
      wait_irq(s0, s1);
      chk("R12 data ack after ignored writes", s1, 8'h28);
      chk("R12 wire byte", got, 8'h3C);
      chk("R12 no stop", stops, 0);

      // R4: repeated START
      go(1, 0, 0);
      wait_irq(s0, s1);
      chk("R4 rstart code", s1, 8'h10);
      chk("R4 start seen", starts, 2);

      // R7: read direction
      wr(3'd3, 8'hA5); go(0, 0, 0);
      wait_irq(s0, s1);
      chk("R7 addr read ack", s1, 8'h40);
      slv_byte = 8'hC3;
      go(0, 0, 1);
      wait_irq(s0, s1);
      chk("R7 rx ack code", s1, 8'h50);
      rdreg(3'd3, v);
      chk("R7 rx byte", v, 8'hC3);
      chk("R7 ack driven", ack_seen, 1);
      slv_byte = 8'h5A;
      go(0, 0, 0);
      wait_irq(s0, s1);
      chk("R7 rx nack code", s1, 8'h58);
      rdreg(3'd3, v);
      chk("R7 rx byte 2", v, 8'h5A);
      chk("R7 nack driven", ack_seen, 0);

      // R11: STOP
      go(0, 1, 0);
      repeat (45) @(negedge clk);
      chk("R11 stop seen", stops, 1);
      chk("R11 no flag", irq, 0);
      chk("R11 scl released", scl_oe, 0);
      chk("R11 sda released", sda_oe, 0);
      chk("R9 status without flag", reg_rdata, 8'hF8);

      // R8: arbitration lost
      go(1, 0, 0);
      wait_irq(s0, s1);
      chk("R8 pre start", s1, 8'h08);
      wr(3'd3, 8'hA0);
      rival = 1'b1;
      st0 = stops;
      go(0, 0, 0);
      wait_irq(s0, s1);
      chk("R8 arb code", s1, 8'h38);
      chk("R8 scl released", scl_oe, 0);
      chk("R8 sda released", sda_oe, 0);
      chk("R8 no stop", stops, st0);
      rival = 1'b0;
      repeat (5) @(negedge clk);
      go(1, 0, 0);
      wait_irq(s0, s1);
      chk("R8 idle after loss", s1, 8'h08);
      go(0, 1, 0);
      repeat (45) @(negedge clk);

      // R2: phase lengths across prescaler and bit rate
      for (int p = 0; p < 4; p++) begin
         for (int b = 1; b < 5; b += 3) begin
            h = 8 + b * (4 ** p);
            wr(3'd0, 8'(b)); wr(3'd1, 8'(p));
            go(1, 0, 0);
            wait_irq(s0, s1);
            wr(3'd3, 8'hA4); go(0, 0, 0);
            while (!scl_l) @(negedge clk);
            hi = 0;
            do begin hi++; @(negedge clk); end while (scl_l);
            lo = 0;
            do begin lo++; @(negedge clk); end while (!scl_l);
            chk($sformatf("R2 high p=%0d b=%0d", p, b), hi, h);
            chk($sformatf("R2 low p=%0d b=%0d", p, b), lo, h);
            wait_irq(s0, s1);
            go(0, 1, 0);
            repeat (3 * h + 10) @(negedge clk);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule